// File: doc/BRIEF.md
# Parallel Data Port Transmit Flow Controller

This block is the sending end of a parallel front-panel data port. It runs on the port strobe clock, takes words from a local buffer through a valid/ready handshake and places them on the parallel bus. A registered active-low data-valid line marks each bus cycle that carries a real word. Two active-low inputs from the receiver can stop the flow: a hold request (pause) and a busy flag (not ready). Both are asynchronous to the strobe clock.

The data-valid line follows rules counted in strobe periods. There is a fixed quiet period after reset. The block stops quickly once the synchronized hold request is seen. After a hold is released, a parameterised minimum idle gap must pass before data-valid returns. The block also drives the active-low direction line. It keeps the two auxiliary programmable I/O drivers switched off until an explicit enable arrives.

Top module: `pbus_tx_ctrl`

## Requirements
- R1: Count the rising strobe edges after reset is released as 1, 2, 3 and so on. No word is transferred on edges 1 to STARTUP_CYC (default 16), so `bus_valid_n` stays 1 until at least edge STARTUP_CYC+1.
- R2: While the synchronized busy input is asserted (`busy_n_async` low), `up_ready` is 0 and no word is transferred.
- R3: A word moves only on an edge where `up_valid` and `up_ready` are both 1. `bus_valid_n` is 0 in exactly the cycle after such an edge and 1 after every other edge, including every edge where the buffer is empty.
- R4: If `hold_n_async` goes low and is sampled on edge e, no transfer happens on edge e+2 or later while it stays low. `bus_valid_n` is therefore 1 from edge e+2 on, well within 16 strobe periods.
- R5: If the release of `hold_n_async` (back to 1) is sampled on edge r, the earliest transfer edge is r+GAP_CYC+2. GAP_CYC is at least 1 and defaults to 2. A one-cycle hold pulse sampled on edge p blocks transfers from edge p+2 through edge p+GAP_CYC+2.
- R6: `hold_n_async` and `busy_n_async` each pass through two flops before use. A change sampled on edge e shows on `up_ready` after edge e+1 and not before.
- R7: `dir_n` is 1 during reset and is driven 0 (transmitting) from the first edge after reset.
- R8: `aux_oe` is all zeros during reset. After each edge it equals `aux_en` as sampled on that edge, replicated to every line. `aux_out` is a registered copy of `aux_val`, reset to 0.
- R9: `bus_data` is 0 after reset. It takes the transferred word in the same cycle that `bus_valid_n` goes 0 and holds that word until the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port strobe clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_data | input | DATA_W | Word offered by the local buffer |
| up_valid | input | 1 | Local buffer holds a word |
| up_ready | output | 1 | Word is taken on this edge if valid |
| hold_n_async | input | 1 | Receiver pause request, active low, asynchronous |
| busy_n_async | input | 1 | Receiver not ready, active low, asynchronous |
| bus_data | output | DATA_W | Parallel bus data, registered |
| bus_valid_n | output | 1 | Bus data valid, active low, registered |
| dir_n | output | 1 | Direction line, active low |
| aux_en | input | 1 | Permission to drive the auxiliary lines |
| aux_val | input | AUX_N | Values for the auxiliary lines |
| aux_out | output | AUX_N | Registered auxiliary line values |
| aux_oe | output | AUX_N | Auxiliary output enables |

## Verification
The hardest case to reach from the ports is the resume timing after a very short hold pulse. A single-cycle dip of `hold_n_async` has to pass through both synchronizer flops and still reload the full idle gap. The stimulus must also keep the buffer full and the busy flag clear, or the gap is hidden. The bench drives a one-cycle pulse with words waiting and compares every cycle against a timestamp-based model. It then checks that the first transfer after the pulse lands on exactly the predicted edge. The same exact-edge check is applied to the start-up quiet period and to the two-edge synchronizer latency.

// File: rtl/pbus_tx_pkg.sv
// Package: shared types for the parallel data port transmitter.
// Assumes: receiver control inputs are active low at the pins.
package pbus_tx_pkg;

    // Receiver-to-transmitter control lines, kept in pin polarity (active low).
    typedef struct packed {
        logic hold_n;
        logic busy_n;
    } pbus_rx_ctl_t;

    localparam int RX_CTL_W = $bits(pbus_rx_ctl_t);

endpackage

// File: rtl/pbus_sync.sv
// Module: pbus_sync
// Multi-stage flop synchronizer for a vector of asynchronous levels.
// Assumes: each bit is independent (no multi-bit coherence needed);
// reset forces every stage to RST_VAL.
module pbus_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First capture flop: samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stages: let a metastable value settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pbus_tx_timer.sv
// Module: pbus_tx_timer
// Counts the start-up quiet period after reset and the minimum idle gap
// that follows each synchronized hold request.
// Assumes: hold_s is already synchronous; GAP_CYC >= 1.
module pbus_tx_timer #(
    parameter int STARTUP_CYC = 16,
    parameter int GAP_CYC     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_s,
    output logic start_done,
    output logic gap_ok
);

    localparam int SW = $clog2(STARTUP_CYC + 1);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam logic [SW-1:0] ST_LIM  = SW'(STARTUP_CYC);
    localparam logic [GW-1:0] GAP_LIM = GW'(GAP_CYC);

    logic [SW-1:0] st_cnt;
    logic [GW-1:0] gap_cnt;

    // Start-up counter: climbs to the limit once after reset, then stays there.
    always_ff @(posedge clk) begin
        if (!rst_n)                st_cnt <= '0;
        else if (st_cnt != ST_LIM) st_cnt <= st_cnt + 1'b1;
    end

    // Gap counter: reloaded while held, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             gap_cnt <= '0;
        else if (hold_s)        gap_cnt <= GAP_LIM;
        else if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
    end

    assign start_done = (st_cnt == ST_LIM);
    assign gap_ok     = !hold_s && (gap_cnt == '0);

    AST_START_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> start_done); // R1
    AST_GAP_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_s) |-> !gap_ok); // R5

endmodule

// File: rtl/pbus_aux_ctrl.sv
// Module: pbus_aux_ctrl
// Registers the auxiliary programmable I/O values and their output enables.
// Assumes: the enables must be off from reset until aux_en is given.
module pbus_aux_ctrl #(
    parameter int AUX_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aux_en,
    input  logic [AUX_N-1:0] aux_val,
    output logic [AUX_N-1:0] aux_out,
    output logic [AUX_N-1:0] aux_oe
);

    // Output enables and values: cleared in reset, registered otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_oe  <= '0;
            aux_out <= '0;
        end else begin
            aux_oe  <= {AUX_N{aux_en}};
            aux_out <= aux_val;
        end
    end

    AST_AUX_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_en |=> (aux_oe == '0)); // R8

endmodule

// File: rtl/pbus_tx_ctrl.sv
// Module: pbus_tx_ctrl (top)
// Transmit flow controller for a parallel data port. Takes words from a
// valid/ready buffer and drives registered data and active-low data-valid,
// honouring start-up delay, receiver busy, hold reaction and resume gap.
// Assumes: clk is the port strobe; hold/busy inputs are asynchronous.
module pbus_tx_ctrl
    import pbus_tx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int STARTUP_CYC = 16,
    parameter int GAP_CYC     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int AUX_N       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              hold_n_async,
    input  logic              busy_n_async,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_valid_n,
    output logic              dir_n,
    input  logic              aux_en,
    input  logic [AUX_N-1:0]  aux_val,
    output logic [AUX_N-1:0]  aux_out,
    output logic [AUX_N-1:0]  aux_oe
);

    pbus_rx_ctl_t ctl_raw;
    pbus_rx_ctl_t ctl_sync;
    logic         hold_s;
    logic         busy_s;
    logic         start_done;
    logic         gap_ok;
    logic         xfer;

    assign ctl_raw.hold_n = hold_n_async;
    assign ctl_raw.busy_n = busy_n_async;

    pbus_sync #(
        .W       (RX_CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({RX_CTL_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_sync)
    );

    assign hold_s = !ctl_sync.hold_n;
    assign busy_s = !ctl_sync.busy_n;

    pbus_tx_timer #(
        .STARTUP_CYC (STARTUP_CYC),
        .GAP_CYC     (GAP_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_s     (hold_s),
        .start_done (start_done),
        .gap_ok     (gap_ok)
    );

    pbus_aux_ctrl #(
        .AUX_N (AUX_N)
    ) u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .aux_en  (aux_en),
        .aux_val (aux_val),
        .aux_out (aux_out),
        .aux_oe  (aux_oe)
    );

    // Ready depends only on registered state, never on up_valid.
    assign up_ready = start_done && gap_ok && !busy_s;
    assign xfer     = up_valid && up_ready;

    // Bus output stage: data and valid change together on the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_valid_n <= 1'b1;
            bus_data    <= '0;
            dir_n       <= 1'b1;
        end else begin
            bus_valid_n <= !xfer;
            dir_n       <= 1'b0;
            if (xfer) bus_data <= up_data;
        end
    end

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !start_done |=> bus_valid_n); // R1
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_s |=> bus_valid_n); // R2
    AST_VALID_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> bus_valid_n); // R3
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> bus_valid_n); // R4
    AST_DIR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dir_n == 1'b0)); // R7
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_n && $past(rst_n)) |-> $stable(bus_data)); // R9

endmodule

// File: tb/pbus_tx_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: timestamp-based behavioural model compared against the DUT every cycle.
module pbus_tx_ctrl_tb_top;

    localparam int DATA_W = 32;
    localparam int START  = 16;
    localparam int GAP    = 2;
    localparam int AUX_N  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] up_data = '0;
    logic              up_valid = 1'b0;
    logic              up_ready;
    logic              hold_n_async = 1'b1;
    logic              busy_n_async = 1'b1;
    logic [DATA_W-1:0] bus_data;
    logic              bus_valid_n;
    logic              dir_n;
    logic              aux_en = 1'b0;
    logic [AUX_N-1:0]  aux_val = '0;
    logic [AUX_N-1:0]  aux_out;
    logic [AUX_N-1:0]  aux_oe;

    always #4 clk = ~clk;

    pbus_tx_ctrl #(
        .DATA_W (DATA_W), .STARTUP_CYC (START), .GAP_CYC (GAP),
        .SYNC_STAGES (2), .AUX_N (AUX_N)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .up_data (up_data), .up_valid (up_valid),
        .up_ready (up_ready), .hold_n_async (hold_n_async),
        .busy_n_async (busy_n_async), .bus_data (bus_data),
        .bus_valid_n (bus_valid_n), .dir_n (dir_n), .aux_en (aux_en),
        .aux_val (aux_val), .aux_out (aux_out), .aux_oe (aux_oe)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Source buffer model
    logic [DATA_W-1:0] q[$];
    bit src_en = 1'b1;

    // Reference model state
    int  rel = 0;            // edges since reset release
    int  last_hold = -1000;  // last edge whose decision saw hold asserted
    bit  h_d1 = 1, h_d2 = 1, b_d1 = 1, b_d2 = 1;
    bit  en_prev = 0;
    logic [AUX_N-1:0] val_prev = '0;
    bit  exp_vn = 1;
    logic [DATA_W-1:0] exp_data = '0;
    bit  exp_dir = 1;
    bit  edge_seen = 0;

    // Port monitors
    int last_low = -1;
    int first_low = -1;
    int min_edge = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_ready(input int n, input bit hd2, input bit bd2,
                                       input int lh);
        bit hold_now, gap_ok, done;
        int lhx;
        hold_now = (hd2 == 1'b0);
        lhx = hold_now ? n : lh;
        gap_ok = !hold_now && ((n - lhx) >= GAP + 1);
        done = (n - 1) >= START;
        return done && gap_ok && (bd2 == 1'b1);
    endfunction

    task automatic tick();
        bit rdy;
        up_valid = src_en && (q.size() > 0);
        up_data  = (q.size() > 0) ? q[0] : '0;
        if (rst_n && edge_seen) begin
            rdy = model_ready(rel + 1, h_d2, b_d2, last_hold);
            chk(up_ready == rdy, "R6", "up_ready", up_ready, rdy);
        end
        @(posedge clk);
        if (!rst_n) begin
            rel = 0; last_hold = -1000;
            exp_vn = 1; exp_data = '0; exp_dir = 1;
            en_prev = 0; val_prev = '0;
            h_d2 = 1; h_d1 = 1; b_d2 = 1; b_d1 = 1;
        end else begin
            rel++;
            rdy = model_ready(rel, h_d2, b_d2, last_hold);
            if (h_d2 == 1'b0) last_hold = rel;
            exp_vn = !(rdy && up_valid);
            if (rdy && up_valid) exp_data = q.pop_front();
            exp_dir = 0;
            h_d2 = h_d1; h_d1 = hold_n_async;
            b_d2 = b_d1; b_d1 = busy_n_async;
            en_prev = aux_en; val_prev = aux_val;
        end
        edge_seen = 1;
        @(negedge clk);
        chk(bus_valid_n == exp_vn, "R3", "bus_valid_n", bus_valid_n, exp_vn);
        chk(bus_data == exp_data, "R9", "bus_data", bus_data, exp_data);
        chk(dir_n == exp_dir, "R7", "dir_n", dir_n, exp_dir);
        chk(aux_oe == {AUX_N{en_prev}}, "R8", "aux_oe", aux_oe, {AUX_N{en_prev}});
        chk(aux_out == val_prev, "R8", "aux_out", aux_out, val_prev);
        if (rst_n && bus_valid_n == 1'b0) begin
            last_low = rel;
            if (first_low < 0 && rel >= min_edge) first_low = rel;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        int n_h, n_r, n_p, n_b;
        for (int i = 0; i < 60; i++) q.push_back(32'hA500_0000 + i);
        rst_n = 0;
        ticks(3);
        chk(bus_valid_n == 1'b1, "R1", "reset bus_valid_n", bus_valid_n, 1);
        chk(dir_n == 1'b1, "R7", "reset dir_n", dir_n, 1);
        chk(aux_oe == '0, "R8", "reset aux_oe", aux_oe, 0);

        // Start-up quiet period
        rst_n = 1; first_low = -1; min_edge = 0;
        ticks(20);
        chk(first_low == START + 1, "R1", "first valid edge", first_low, START + 1);
        chk(aux_oe == '0, "R8", "aux_oe without enable", aux_oe, 0);

        // Buffer runs empty, then refills
        src_en = 0;
        ticks(2);
        chk(bus_valid_n == 1'b1, "R3", "valid while empty", bus_valid_n, 1);
        ticks(2);
        src_en = 1;
        ticks(3);

        // Receiver busy
        busy_n_async = 0;
        ticks(4);
        chk(bus_valid_n == 1'b1, "R2", "valid while busy", bus_valid_n, 1);
        chk(up_ready == 1'b0, "R2", "ready while busy", up_ready, 0);
        busy_n_async = 1;
        ticks(5);

        // Hold: reaction and resume gap
        n_h = rel + 1;
        hold_n_async = 0;
        ticks(20);
        chk(last_low < n_h + 16, "R4", "last valid during hold", last_low, n_h + 1);
        chk(last_low == n_h + 1, "R4", "hold reaction edge", last_low, n_h + 1);
        n_r = rel + 1;
        first_low = -1; min_edge = n_r;
        hold_n_async = 1;
        ticks(10);
        chk(first_low == n_r + GAP + 2, "R5", "resume edge", first_low, n_r + GAP + 2);

        // One-cycle hold pulse with words waiting
        n_p = rel + 1;
        first_low = -1; min_edge = n_p + 2;
        hold_n_async = 0;
        tick();
        hold_n_async = 1;
        ticks(10);
        chk(first_low == n_p + GAP + 3, "R5", "resume after pulse", first_low, n_p + GAP + 3);

        // Synchronizer latency on busy
        n_b = rel + 1;
        busy_n_async = 0;
        tick();
        chk(up_ready == 1'b1, "R6", "ready one edge after busy", up_ready, 1);
        tick();
        chk(up_ready == 1'b0, "R6", "ready two edges after busy", up_ready, 0);
        busy_n_async = 1;
        ticks(3);
        chk(rel == n_b + 4, "R6", "edge bookkeeping", rel, n_b + 4);

        // Auxiliary enable
        aux_en = 1; aux_val = 2'b10;
        ticks(2);
        chk(aux_oe == 2'b11, "R8", "aux_oe enabled", aux_oe, 2'b11);
        chk(aux_out == 2'b10, "R8", "aux_out value", aux_out, 2'b10);
        aux_en = 0;
        tick();
        chk(aux_oe == '0, "R8", "aux_oe disabled", aux_oe, 0);

        // Drain the buffer completely
        ticks(60);
        chk(q.size() == 0, "R3", "buffer drained", q.size(), 0);
        chk(bus_valid_n == 1'b1, "R3", "valid after drain", bus_valid_n, 1);
        chk(bus_data == 32'hA500_0000 + 59, "R9", "last word held", bus_data,
            32'hA500_0000 + 59);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule